// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block collects interrupt requests from external pins and from an on-chip converter for a small 8-bit microcontroller core. Each pin is brought into the clock domain through a two-flop synchronizer. A qualifier then accepts a level change only when the new level has been stable for a programmable number of clocks. When an accepted change is a falling one, a pending flag is set. The flag stays latched until the CPU acknowledges its vector or software clears it.

Every vector has its own enable bit. The enabled pending flags go through a fixed-priority encoder: the lowest-numbered vector wins, and its 3-bit index is presented to the CPU together with the request. The same condition drives a wake output that lets the core leave its idle state.

The highest vector is shared by the last external pin and by a converter completion strobe. Each of these two sources owns a sub-flag and a sub-enable. A group flag on the shared vector follows the enabled sub-flags. Neither the group flag nor the sub-flags are ever cleared by an acknowledge, so software has to clear them.

Top module: `eirq_ctrl`

## Requirements
- R1: After reset, every flag, enable, sub-flag and sub-enable reads 0, and both `irq_req_o` and `wake_o` are 0.
- R2: A pin flag is set only after the synchronized pin has been low for QUAL_CYC (default 5) consecutive clocks. A low pulse of QUAL_CYC-1 clocks or shorter leaves the flag at 0. A rising edge never sets a flag.
- R3: Once set, a flag stays set after the pin returns high. It clears only through an acknowledge or a software clear.
- R4: Clearing an enable bit removes that vector from the request but does not clear its pending flag. Setting the enable again brings the request back.
- R5: Register address 0 is the enable register: bit k is the enable of vector k, and it can be written and read back. Bits at or above N_PIN read as 0. Address 1 reads the pending flags, with bit k belonging to vector k.
- R6: Writing 1 to bit k at address 1 clears flag k, and writing 0 has no effect. If a hardware set lands in the same clock as a software clear, the flag ends up set.
- R7: An acknowledge (`ack_i`) carrying the index of a non-shared vector clears that flag on the next clock and leaves every other flag unchanged.
- R8: On the shared vector (index N_PIN-1), register 3 holds the sub-flags: bit 0 is set by a qualified fall on the last pin, and bit 1 is set by a one-cycle `cvt_done_i` strobe. Register 2 holds the matching sub-enables. Writing 1 to a bit of register 3 clears that sub-flag.
- R9: The group flag (bit N_PIN-1 of address 1) is set while any enabled sub-flag is pending. An acknowledge of the shared vector clears neither the group flag nor the sub-flags.
- R10: When any enabled flags are pending, `irq_req_o` is 1 and `irq_vec_o` gives the lowest pending index. Otherwise `irq_req_o` is 0.
- R11: `wake_o` is 1 exactly when `irq_req_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | N_PIN | External interrupt pins, active low |
| cvt_done_i | input | 1 | Converter completion strobe, one cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational on the address |
| ack_i | input | 1 | CPU acknowledge of a vector |
| ack_vec_i | input | VW | Index of the acknowledged vector |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | VW | Index of the highest-priority pending vector |
| wake_o | output | 1 | Wake request for the low-power state |

## Verification
The assertions assume the acknowledge index is below N_PIN whenever `ack_i` is high. They also assume the CPU acknowledges only while a request is shown. The stimulus acknowledges only vectors that exist, and only after it has raised their flags.

Pin pulses are driven on the falling clock edge and held for whole clocks. After each pulse, the pin stays high for longer than a qualification window, so the next fall always starts from an accepted high level. The same-cycle set-versus-clear case uses a write that is timed to the exact clock on which qualification completes.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    REG_EN     = 2'd0,
    REG_FLG    = 2'd1,
    REG_SUBEN  = 2'd2,
    REG_SUBFLG = 2'd3
  } eirq_reg_e;

  localparam int unsigned SUB_PIN = 0;
  localparam int unsigned SUB_CVT = 1;
endpackage

// File: rtl/eirq_qual.sv
module eirq_qual #(
  parameter int unsigned QUAL = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);

  logic          s1_q, s2_q, lvl_q, lvl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          mismatch, hit;

  always_comb begin
    mismatch = s2_q ^ lvl_q;
    hit      = mismatch && (cnt_q == CW'(QUAL - 1));
    lvl_d    = hit ? s2_q : lvl_q;
    if (!mismatch || hit) cnt_d = '0;
    else                  cnt_d = cnt_q + CW'(1);
    fall_o   = hit && !s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      s1_q  <= pin_i;
      s2_q  <= s1_q;
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eirq_prio.sv
module eirq_prio #(
  parameter int unsigned NV = 4,
  parameter int unsigned VW = 3
) (
  input  logic [NV-1:0] req_i,
  output logic          any_o,
  output logic [VW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VW'(i);
    end
  end
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl #(
  parameter int unsigned N_PIN    = 4,
  parameter int unsigned QUAL_CYC = 5,
  parameter int unsigned DW       = 8,
  parameter int unsigned VW       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] ext_n_i,
  input  logic             cvt_done_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             ack_i,
  input  logic [VW-1:0]    ack_vec_i,
  output logic             irq_req_o,
  output logic [VW-1:0]    irq_vec_o,
  output logic             wake_o
);
  import eirq_pkg::*;

  localparam int unsigned SHV = N_PIN - 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_m_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s   <= rst_m_q;
    end
  end

  // edge qualification per pin
  logic [N_PIN-1:0] fall;
  for (genvar k = 0; k < N_PIN; k++) begin : g_qual
    eirq_qual #(.QUAL(QUAL_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_s),
      .pin_i  (ext_n_i[k]),
      .fall_o (fall[k])
    );
  end

  logic [N_PIN-1:0] en_q, en_d, flg_q, flg_d, set, sw_clr, ack_clr;
  logic [1:0]       suben_q, suben_d, subflg_q, subflg_d, sub_set, sub_clr;
  logic             we_en, we_flg, we_suben, we_subflg;
  logic [N_PIN-1:0] pend;

  always_comb begin
    we_en     = reg_wr_i && (reg_addr_i == REG_EN);
    we_flg    = reg_wr_i && (reg_addr_i == REG_FLG);
    we_suben  = reg_wr_i && (reg_addr_i == REG_SUBEN);
    we_subflg = reg_wr_i && (reg_addr_i == REG_SUBFLG);
    sw_clr    = we_flg    ? reg_wdata_i[N_PIN-1:0] : '0;
    sub_clr   = we_subflg ? reg_wdata_i[1:0]       : '0;
  end

  for (genvar k = 0; k < N_PIN; k++) begin : g_vec
    if (k == SHV) begin : g_shared
      assign ack_clr[k] = 1'b0;
      assign set[k]     = |(subflg_q & suben_q);
    end else begin : g_plain
      assign ack_clr[k] = ack_i && (ack_vec_i == VW'(k));
      assign set[k]     = fall[k];
    end
  end

  always_comb begin
    sub_set           = '0;
    sub_set[SUB_PIN]  = fall[SHV];
    sub_set[SUB_CVT]  = cvt_done_i;
    flg_d    = set | (flg_q & ~sw_clr & ~ack_clr);
    subflg_d = sub_set | (subflg_q & ~sub_clr);
    en_d     = reg_wdata_i[N_PIN-1:0];
    suben_d  = reg_wdata_i[1:0];
    pend     = flg_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q     <= '0;
      flg_q    <= '0;
      suben_q  <= '0;
      subflg_q <= '0;
    end else begin
      if (we_en)    en_q    <= en_d;
      if (we_suben) suben_q <= suben_d;
      flg_q    <= flg_d;
      subflg_q <= subflg_d;
    end
  end

  eirq_prio #(.NV(N_PIN), .VW(VW)) u_prio (
    .req_i (pend),
    .any_o (irq_req_o),
    .idx_o (irq_vec_o)
  );

  assign wake_o = irq_req_o;

  always_comb begin
    case (reg_addr_i)
      REG_EN:    reg_rdata_o = DW'(en_q);
      REG_FLG:   reg_rdata_o = DW'(flg_q);
      REG_SUBEN: reg_rdata_o = DW'(suben_q);
      default:   reg_rdata_o = DW'(subflg_q);
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
  parameter int unsigned N_PIN = 4,
  parameter int unsigned DW    = 8,
  parameter int unsigned VW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic [VW-1:0]    ack_vec_i,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic             irq_req_o,
  input logic [VW-1:0]    irq_vec_o,
  input logic [N_PIN-1:0] flg_q,
  input logic [N_PIN-1:0] en_q,
  input logic [N_PIN-1:0] fall
);
  localparam int unsigned SHV = N_PIN - 1;

  logic [N_PIN-1:0] pend, below, sel;
  logic             wr_flg;
  always_comb begin
    pend   = flg_q & en_q;
    wr_flg = reg_wr_i && (reg_addr_i == 2'd1);
    for (int k = 0; k < N_PIN; k++) begin
      below[k] = (VW'(k) < irq_vec_o);
      sel[k]   = (VW'(k) == irq_vec_o);
    end
  end

  // R10
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (((pend & below) == '0) && ((pend & sel) != '0)));

  // R10
  req_has_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> irq_req_o);

  for (genvar k = 0; k < N_PIN; k++) begin : g_bit
    if (k != SHV) begin : g_plain
      // R3
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[k] && !(ack_i && ack_vec_i == VW'(k)) && !(wr_flg && reg_wdata_i[k]))
        |=> flg_q[k]);
      // R7
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ack_vec_i == VW'(k) && !fall[k]) |=> !flg_q[k]);
    end else begin : g_shared
      // R9
      shared_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q[k] && !(wr_flg && reg_wdata_i[k])) |=> flg_q[k]);
    end
  end
endmodule

bind eirq_ctrl eirq_ctrl_chk #(.N_PIN(N_PIN), .DW(DW), .VW(VW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s),
  .ack_i       (ack_i),
  .ack_vec_i   (ack_vec_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_req_o   (irq_req_o),
  .irq_vec_o   (irq_vec_o),
  .flg_q       (flg_q),
  .en_q        (en_q),
  .fall        (fall)
);

// File: tb/tb_eirq_ctrl.sv
module tb_eirq_ctrl;
  localparam int N_PIN = 4;
  localparam int QUAL  = 5;
  localparam int DW    = 8;
  localparam int VW    = 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [N_PIN-1:0] ext_n;
  logic             cvt_done, reg_wr, ack;
  logic [1:0]       reg_addr;
  logic [DW-1:0]    reg_wdata, reg_rdata;
  logic [VW-1:0]    ack_vec, irq_vec;
  logic             irq_req, wake;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] rv;

  always #5 clk = ~clk;

  eirq_ctrl #(.N_PIN(N_PIN), .QUAL_CYC(QUAL), .DW(DW), .VW(VW)) dut (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .cvt_done_i(cvt_done),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ack_i(ack), .ack_vec_i(ack_vec),
    .irq_req_o(irq_req), .irq_vec_o(irq_vec), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N_PIN-1:0] m, input int len);
    @(negedge clk);
    ext_n = ext_n & ~m;
    repeat (len) @(negedge clk);
    ext_n = ext_n | m;
    repeat (14) @(negedge clk);
  endtask

  task automatic do_ack(input logic [VW-1:0] v);
    @(negedge clk);
    ack = 1'b1; ack_vec = v;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; ext_n = '1; cvt_done = 1'b0; reg_wr = 1'b0; ack = 1'b0;
    reg_addr = '0; reg_wdata = '0; ack_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv);
      chk("R1 regs", rv, 0);
    end
    chk("R1 irq_req", irq_req, 0);
    chk("R1 wake", wake, 0);

    // R5 enable readback over every pattern, upper bits read 0
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 8'(m) | 8'hF0);
      rd(2'd0, rv);
      chk("R5 enable readback", rv, m);
    end

    // R2, R3 pulse width sweep on the plain pins
    wr(2'd0, 8'h0F);
    for (int k = 0; k < N_PIN - 1; k++) begin
      for (int len = 1; len <= 7; len++) begin
        pulse(4'(1 << k), len);
        rd(2'd1, rv);
        chk("R2/R3 width sweep", rv, (len >= QUAL) ? (1 << k) : 0);
        chk("R11 wake", wake, (len >= QUAL) ? 1 : 0);
        wr(2'd1, 8'hFF);
      end
    end

    // R6 software clear of nothing pending leaves 0; set wins over clear
    wr(2'd1, 8'h01);
    rd(2'd1, rv);
    chk("R6 clear idle", rv, 0);
    @(negedge clk);
    ext_n[0] = 1'b0;
    repeat (6) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    ext_n[0] = 1'b1;
    rd(2'd1, rv);
    chk("R6 set wins", rv, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, rv);
    chk("R6 write zero keeps", rv, 1);
    wr(2'd1, 8'h01);
    rd(2'd1, rv);
    chk("R6 write one clears", rv, 0);
    repeat (10) @(negedge clk);

    // R4 masking keeps the flag
    wr(2'd0, 8'h00);
    pulse(4'b0001, 6);
    rd(2'd1, rv);
    chk("R4 flag while masked", rv, 1);
    chk("R4 no req while masked", irq_req, 0);
    wr(2'd0, 8'h01);
    #1 chk("R4 req after enable", irq_req, 1);
    chk("R4 vec", irq_vec, 0);
    wr(2'd0, 8'h00);
    rd(2'd1, rv);
    chk("R4 flag survives disable", rv, 1);

    // R10 priority over every enable mask
    pulse(4'b0110, 6);
    for (int m = 0; m < 8; m++) begin
      int lo;
      lo = 0;
      for (int b = 2; b >= 0; b--) if (m[b]) lo = b;
      wr(2'd0, 8'(m));
      #1;
      chk("R10 req", irq_req, (m != 0) ? 1 : 0);
      if (m != 0) chk("R10 vec", irq_vec, lo);
      chk("R11 wake tracks", wake, irq_req);
    end

    // R7 acknowledge clears only its own flag
    do_ack(3'd1);
    rd(2'd1, rv);
    chk("R7 ack vec1", rv, 8'h05);
    do_ack(3'd0);
    rd(2'd1, rv);
    chk("R7 ack vec0", rv, 8'h04);
    #1 chk("R7 next vec", irq_vec, 2);
    wr(2'd1, 8'h04);

    // R8, R9 shared vector from the converter
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h02);
    @(negedge clk); cvt_done = 1'b1;
    @(negedge clk); cvt_done = 1'b0;
    rd(2'd3, rv);
    chk("R8 cvt subflag", rv, 2);
    rd(2'd1, rv);
    chk("R9 group flag", rv, 8'h08);
    chk("R10 shared vec", irq_vec, 3);
    do_ack(3'd3);
    rd(2'd1, rv);
    chk("R9 group kept on ack", rv, 8'h08);
    rd(2'd3, rv);
    chk("R9 sub kept on ack", rv, 2);
    wr(2'd1, 8'h08);
    rd(2'd1, rv);
    chk("R9 group re-set by sub", rv, 8'h08);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'h08);
    rd(2'd1, rv);
    chk("R9 group cleared", rv, 0);
    chk("R9 req gone", irq_req, 0);

    // R8 masked sub source does not raise the group
    wr(2'd2, 8'h00);
    @(negedge clk); cvt_done = 1'b1;
    @(negedge clk); cvt_done = 1'b0;
    rd(2'd3, rv);
    chk("R8 masked subflag", rv, 2);
    rd(2'd1, rv);
    chk("R8 masked group", rv, 0);
    wr(2'd3, 8'h02);

    // R8 shared pin source
    wr(2'd2, 8'h01);
    pulse(4'b1000, 6);
    rd(2'd3, rv);
    chk("R8 pin subflag", rv, 1);
    rd(2'd1, rv);
    chk("R8 pin group", rv, 8'h08);
    pulse(4'b1000, 3);
    rd(2'd3, rv);
    chk("R2 short shared pulse", rv, 1);

    finish_run();
  end
endmodule